// File: doc/BRIEF.md
# PWM Prescaler Tick Generator

This block turns the master clock into a bank of count-enable pulses for a group of PWM channels. A free-running binary counter supplies eleven power-of-two rates: the master clock divided by 1, 2, 4 and so on up to 1024. Two linear dividers sit beside it. Each one picks one of those eleven rates as its source and divides it again by an 8-bit integer. This gives thirteen selectable rates in total.

Every output is a one-cycle-wide enable pulse in the master clock domain, and no output is a derived clock. A channel chooses one of the thirteen bits and advances its counter only in cycles where that bit is high. The divider settings come in as static configuration inputs. When a divider's setting changes, that divider drops its partial count and starts again from zero.

Top module: `pwm_tick_gen`

## Requirements
- R1: While `rst` is high, every bit of `tick_o` is 0, and a synchronous reset also returns the prescaler phase to its start.
- R2: Tap k (bits 0 to 10 of `tick_o`) pulses for one cycle every 2^k cycles. Bit 0 is high in every cycle out of reset. Count the first cycle after reset release as cycle 0. Bit k is then first high in cycle 2^k-1.
- R3: Whenever tap k pulses, every tap below k pulses in the same cycle.
- R4: Divider d drives bit 11+d of `tick_o`. Its tap select sits in `div_sel_i[4d+3:4d]` and its factor N in `div_factor_i[8d+7:8d]`. With a valid tap t and N from 1 to 255, it pulses once every N*2^t cycles.
- R5: A divider pulses only in a cycle where its selected tap pulses.
- R6: A divide factor of 0 keeps that divider's output at 0.
- R7: A tap select of 11 to 15 keeps that divider's output at 0.
- R8: A change to either field of a divider's setting restarts its count. There is no pulse in the cycle where the new value first appears. With tap 0, the first pulse comes exactly N cycles after that cycle.
- R9: The two dividers run independently, and each keeps its own rate whatever the other is set to.
- R10: A divider pulse lasts a single cycle, unless the tap is 0 and the factor is 1 (a pulse in every cycle).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel_i | input | 8 | Tap select for each divider, 4 bits per divider |
| div_factor_i | input | 16 | Divide factor for each divider, 8 bits per divider |
| tick_o | output | 13 | Enables: taps 0..10, then divider 0 and divider 1 |

## Verification
The divider assertions treat the configuration inputs as quasi-static. They may change in any cycle, but the count is expected to restart, so the pulse-width property is only checked under the setting in force during the pulse. The bench changes settings just after a falling edge and holds them for at least a full measured period. Every factor and tap it uses is chosen from the legal range, except for the deliberate off cases, so the rate checks rely on stable settings.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
    localparam int TAP_NUM = 11;
    localparam int SEL_W   = $clog2(TAP_NUM);
    localparam int FAC_W   = 8;
    localparam int DIV_NUM = 2;
    localparam int OUT_NUM = TAP_NUM + DIV_NUM;
    localparam int PRE_W   = TAP_NUM - 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [FAC_W-1:0] factor;
    } div_cfg_t;

    function automatic logic sel_in_range(logic [SEL_W-1:0] s);
        return 32'(s) < TAP_NUM;
    endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import pwm_tick_pkg::*;
#(
    parameter int TAPS = TAP_NUM
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TAPS-1:0] tap_o
);
    localparam int CW = TAPS - 1;

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + 1'b1;
    end

    assign tap_o[0] = !rst;

    generate
        for (genvar k = 1; k < TAPS; k++) begin : g_tap
            assign tap_o[k] = !rst && (&phase_q[k-1:0]);

            // R3
            tap_nest_chk: assert property (@(posedge clk) disable iff (rst)
                tap_o[k] |-> tap_o[k-1]);
        end
    endgenerate

    // R2
    tap_half_rate_chk: assert property (@(posedge clk) disable iff (rst)
        tap_o[1] |=> !tap_o[1]);
endmodule

// File: rtl/lin_divider.sv
module lin_divider
    import pwm_tick_pkg::*;
#(
    parameter int TAPS = TAP_NUM
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TAPS-1:0] taps_i,
    input  div_cfg_t        cfg_i,
    output logic            pulse_o
);
    div_cfg_t         cfg_q;
    logic [FAC_W-1:0] cnt_q;
    logic             src;
    logic             active;
    logic             changed;
    logic             at_end;

    always_comb begin
        src = 1'b0;
        for (int i = 0; i < TAPS; i++) begin
            if (cfg_i.sel == SEL_W'(i)) src = taps_i[i];
        end
    end

    assign active  = (cfg_i.factor != '0);
    assign changed = (cfg_i != cfg_q);
    assign at_end  = (cnt_q == cfg_i.factor - 1'b1);
    assign pulse_o = src && active && !changed && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cnt_q <= '0;
        end else begin
            cfg_q <= cfg_i;
            if (changed)             cnt_q <= '0;
            else if (src && active)  cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    // R5
    src_align_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> (sel_in_range(cfg_i.sel) && taps_i[cfg_i.sel[SEL_W-1:0]]));

    // R6
    zero_factor_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.factor == '0) |-> !pulse_o);

    // R7
    bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_in_range(cfg_i.sel) |-> !pulse_o);

    // R8
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_i != $past(cfg_i)) |-> !pulse_o);

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && (cfg_i.factor > 8'd1 || cfg_i.sel != '0)) |=> !pulse_o);
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_tick_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DIV_NUM*SEL_W-1:0] div_sel_i,
    input  logic [DIV_NUM*FAC_W-1:0] div_factor_i,
    output logic [OUT_NUM-1:0]       tick_o
);
    logic [TAP_NUM-1:0] taps;
    logic [DIV_NUM-1:0] div_pulse;

    tick_prescaler #(.TAPS(TAP_NUM)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .tap_o (taps)
    );

    generate
        for (genvar d = 0; d < DIV_NUM; d++) begin : g_div
            div_cfg_t cfg;
            assign cfg.sel    = div_sel_i[d*SEL_W +: SEL_W];
            assign cfg.factor = div_factor_i[d*FAC_W +: FAC_W];

            lin_divider #(.TAPS(TAP_NUM)) u_div (
                .clk     (clk),
                .rst     (rst),
                .taps_i  (taps),
                .cfg_i   (cfg),
                .pulse_o (div_pulse[d])
            );
        end
    endgenerate

    assign tick_o = {div_pulse, taps};

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> (tick_o == '0));
endmodule

// File: tb/pwm_tick_gen_bench.sv
module pwm_tick_gen_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  sel;
    logic [15:0] fac;
    logic [12:0] tick;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    pwm_tick_gen u_pwm_tick_gen (
        .clk          (clk),
        .rst          (rst),
        .div_sel_i    (sel),
        .div_factor_i (fac),
        .tick_o       (tick)
    );

    localparam int NV = 7;
    localparam int V_T0 [NV] = '{0, 0, 3, 2,   10,   1, 5};
    localparam int V_F0 [NV] = '{1, 7, 5, 255, 3,    1, 200};
    localparam int V_P0 [NV] = '{1, 7, 40, 1020, 3072, 2, 6400};
    localparam int V_T1 [NV] = '{4, 0, 0, 6,   1,    3, 0};
    localparam int V_F1 [NV] = '{3, 2, 9, 1,   4,  250, 255};
    localparam int V_P1 [NV] = '{48, 2, 9, 64, 8, 2000, 255};

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_div(int d, int t, int f);
        sel[d*4 +: 4] = 4'(t);
        fac[d*8 +: 8] = 8'(f);
    endtask

    task automatic wait_pulse(int b, int limit, output int found);
        found = 0;
        for (int i = 0; i < limit && found == 0; i++) begin
            @(negedge clk);
            if (tick[b]) found = 1;
        end
    endtask

    task automatic measure(int b, output int period, output int after);
        int f, t1;
        period = -1;
        after = -1;
        wait_pulse(b, 20000, f);
        if (f == 0) return;
        t1 = cyc;
        wait_pulse(b, 20000, f);
        if (f == 0) return;
        period = cyc - t1;
        @(negedge clk);
        after = int'(tick[b]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int first [11];
        int count [11];
        int nest_bad;
        int p, a, hits, at3;

        rst = 1'b1;
        sel = '0;
        fac = '0;
        set_div(0, 0, 1);
        set_div(1, 0, 1);
        repeat (3) @(negedge clk);
        check_eq("R1", "ticks in reset", int'(tick), 0);

        // R2 / R3: tap phases and rates from release
        for (int k = 0; k < 11; k++) begin
            first[k] = -1;
            count[k] = 0;
        end
        nest_bad = 0;
        @(negedge clk);
        rst = 1'b0;
        for (int j = 0; j < 2048; j++) begin
            if (j > 0) @(negedge clk);
            else #1;
            for (int k = 0; k < 11; k++) begin
                if (tick[k]) begin
                    count[k]++;
                    if (first[k] < 0) first[k] = j;
                    if (k > 0 && !tick[k-1]) nest_bad++;
                end
            end
        end
        for (int k = 0; k < 11; k++) begin
            check_eq("R2", $sformatf("tap %0d first cycle", k), first[k], (1 << k) - 1);
            check_eq("R2", $sformatf("tap %0d pulses in 2048", k), count[k], 2048 >> k);
        end
        check_eq("R3", "nesting violations", nest_bad, 0);

        // R4 / R9 / R10: table of divider settings
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            set_div(0, V_T0[v], V_F0[v]);
            set_div(1, V_T1[v], V_F1[v]);
            measure(11, p, a);
            check_eq("R4", $sformatf("div0 period vec %0d", v), p, V_P0[v]);
            if (V_P0[v] > 1) check_eq("R10", $sformatf("div0 width vec %0d", v), a, 0);
            measure(12, p, a);
            check_eq("R9", $sformatf("div1 period vec %0d", v), p, V_P1[v]);
            if (V_P1[v] > 1) check_eq("R10", $sformatf("div1 width vec %0d", v), a, 0);
        end

        // R6 / R7: off settings
        @(negedge clk);
        set_div(0, 0, 0);
        set_div(1, 12, 1);
        hits = 0;
        a = 0;
        for (int j = 0; j < 2000; j++) begin
            @(negedge clk);
            if (tick[11]) hits++;
            if (tick[12]) a++;
        end
        check_eq("R6", "factor 0 pulses", hits, 0);
        check_eq("R7", "tap select 12 pulses", a, 0);

        // R5: divider pulses coincide with selected tap
        @(negedge clk);
        set_div(0, 4, 2);
        hits = 0;
        for (int j = 0; j < 400; j++) begin
            @(negedge clk);
            if (tick[11] && !tick[4]) hits++;
        end
        check_eq("R5", "pulses off tap 4", hits, 0);

        // R8: factor change restarts count
        @(negedge clk);
        set_div(0, 0, 5);
        repeat (7) @(negedge clk);
        set_div(0, 0, 3);
        #1;
        check_eq("R8", "pulse in change cycle", int'(tick[11]), 0);
        at3 = 0;
        hits = 0;
        for (int j = 1; j <= 3; j++) begin
            @(negedge clk);
            if (tick[11]) begin
                if (j == 3) at3 = 1;
                else hits++;
            end
        end
        check_eq("R8", "early pulses after factor change", hits, 0);
        check_eq("R8", "pulse at cycle 3 after factor change", at3, 1);

        // R8: tap-only change restarts count
        @(negedge clk);
        set_div(0, 1, 3);
        repeat (10) @(negedge clk);
        set_div(0, 0, 3);
        #1;
        check_eq("R8", "pulse in tap change cycle", int'(tick[11]), 0);
        at3 = 0;
        hits = 0;
        for (int j = 1; j <= 3; j++) begin
            @(negedge clk);
            if (tick[11]) begin
                if (j == 3) at3 = 1;
                else hits++;
            end
        end
        check_eq("R8", "early pulses after tap change", hits, 0);
        check_eq("R8", "pulse at cycle 3 after tap change", at3, 1);

        // R1: reset in mid-run
        @(negedge clk);
        set_div(1, 0, 1);
        rst = 1'b1;
        @(negedge clk);
        check_eq("R1", "ticks in mid-run reset", int'(tick), 0);
        rst = 1'b0;
        #1;
        check_eq("R2", "tap 0 right after release", int'(tick[0]), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule